// File: doc/BRIEF.md
# Buffered Reference Period Generator

This block produces a square reference waveform for a servo loop. A 16-bit counter advances on each cycle where the clock-enable input is high. When it reaches the active period value, the output inverts and the counter restarts from zero. The value software programs is therefore the half-period of the waveform. One half-period lasts (value + 1) enabled ticks.

Software never writes the active compare value directly. A word written to the period register is held in a shadow buffer. The buffer is copied into the active register on the next compare match, so the waveform changes period only at a clean boundary. For initialisation, a read of the period register copies the buffer into the active register at once.

An external video flip-flop signal can resynchronise the waveform. The signal first passes through a two-flop synchroniser. A chosen edge of it then clears the counter, but only while a playback-with-fixed-drum-phase qualifier is asserted and the reload is enabled.

Top module: `ref_period_gen`

## Requirements
- R1: After `rst`, `ref_out` is low and the counter is zero. The shadow buffer and the active period both hold 0xFFFF. Both control bits are cleared, so a control read returns 0.
- R2: With `tick_en` held high and an active period value P, `ref_out` inverts every P+1 clock cycles. At each inversion the counter restarts from zero.
- R3: A bus write to address 0 (period) changes only the shadow buffer. The half-period in progress completes with the old value. The buffer is copied into the active period at the compare match that ends that half-period.
- R4: A bus read of address 0 copies the shadow buffer into the active period at that clock edge. The read leaves `ref_out` unchanged and returns 0 on `bus_rdata`.
- R5: While `lp_init` (standby or module stop) is high, the shadow buffer and the active period are set to 0xFFFF. During that time the counter is cleared, `ref_out` is driven low and period writes are ignored. The control bits keep their values.
- R6: Address 1 is the control register. Bit 0 enables the video reload. Bit 1 selects the reload edge: 0 selects rising, 1 selects falling. A read of address 1 returns these two bits with all other bits zero. Writes ignore bits 15..2.
- R7: Suppose the reload is enabled, `pb_fixed` is high and `vff_in` makes the selected transition, and the new level is first sampled at clock edge k. The counter is then cleared at edge k+2. The reload does not invert `ref_out` and does not copy the buffer.
- R8: A `vff_in` transition causes no reload in any of these cases: the reload is disabled, `pb_fixed` is low, or the transition is the unselected edge. The half-period is unaffected.
- R9: When a reload and a compare match fall on the same edge, the reload wins. The counter clears, `ref_out` does not invert and the buffer is not copied.
- R10: While `tick_en` is low the counter holds its value and no match can occur. With `tick_en` high on every second cycle, the half-period doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_init | input | 1 | Standby / module-stop initialisation, active high |
| tick_en | input | 1 | Counter clock enable |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (full 16-bit word) |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 1 | 0 = period register, 1 = control register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pb_fixed | input | 1 | Playback with fixed drum phase; qualifies the video reload |
| vff_in | input | 1 | Asynchronous video flip-flop signal |
| ref_out | output | 1 | Reference square wave |

## Verification
The counter and the period registers are not visible at the ports, so a fault in them shows up as a wrong interval between `ref_out` inversions. A wrong active value or a lost increment moves the next inversion by at least one cycle. That error appears within one half-period, and the cycle-by-cycle comparison flags it on that cycle. A buffer that is copied too early or too late shows up one half-period after the write. A missed or spurious video reload moves the next inversion by the count that had built up, on the order of twenty cycles in the tested setups.

// File: rtl/ref_period_pkg.sv
package ref_period_pkg;

    typedef enum logic {
        ADDR_PERIOD = 1'b0,
        ADDR_CTRL   = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic edge_fall;   // bit 1: 1 = falling edge reloads
        logic rl_en;       // bit 0: video reload enable
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    function automatic logic pick_edge(input logic cur, input logic prev, input logic fall);
        return fall ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/rpg_regs.sv
module rpg_regs
    import ref_period_pkg::*;
#(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lp_init,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [PER_W-1:0] bus_wdata,
    input  logic             match,
    output logic [PER_W-1:0] bus_rdata,
    output logic [PER_W-1:0] act_per,
    output logic [PER_W-1:0] buf_per,
    output ctrl_t            ctrl,
    output logic             force_xfer
);
    localparam logic [PER_W-1:0] ALL_ONES = '1;

    logic wr_period, wr_ctrl, rd_ctrl;

    assign wr_period  = bus_sel & bus_wr & (reg_addr_e'(bus_addr) == ADDR_PERIOD);
    assign wr_ctrl    = bus_sel & bus_wr & (reg_addr_e'(bus_addr) == ADDR_CTRL);
    assign rd_ctrl    = bus_sel & bus_rd & (reg_addr_e'(bus_addr) == ADDR_CTRL);
    assign force_xfer = bus_sel & bus_rd & (reg_addr_e'(bus_addr) == ADDR_PERIOD);

    // Shadow buffer and active compare value
    always_ff @(posedge clk) begin
        if (rst || lp_init) begin
            buf_per <= ALL_ONES;
            act_per <= ALL_ONES;
        end else begin
            if (match || force_xfer) act_per <= buf_per;
            if (wr_period)           buf_per <= bus_wdata;
        end
    end

    // Control bits survive low-power initialisation
    always_ff @(posedge clk) begin
        if (rst)          ctrl <= '0;
        else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_ctrl) bus_rdata = {{(PER_W-CTRL_W){1'b0}}, ctrl};
    end
endmodule

// File: rtl/rpg_vsync.sv
module rpg_vsync
    import ref_period_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vff_in,
    input  logic rl_en,
    input  logic edge_fall,
    input  logic gate,
    output logic reload
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= vff_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], vff_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign reload = rl_en & gate & pick_edge(sync_q[SYNC_STAGES-1], prev_q, edge_fall);
endmodule

// File: rtl/rpg_counter.sv
module rpg_counter #(
    parameter int unsigned PER_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lp_init,
    input  logic             tick_en,
    input  logic [PER_W-1:0] act_per,
    input  logic             reload,
    output logic [PER_W-1:0] cnt_q,
    output logic             match,
    output logic             ref_out
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    // Reload takes priority over a match on the same edge
    assign match = tick_en & (cnt_q == act_per) & ~reload;

    always_ff @(posedge clk) begin
        if (rst || lp_init) begin
            cnt_q   <= '0;
            ref_out <= 1'b0;
        end else if (reload) begin
            cnt_q   <= '0;
        end else if (match) begin
            cnt_q   <= '0;
            ref_out <= ~ref_out;
        end else if (tick_en) begin
            cnt_q   <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/ref_period_gen.sv
module ref_period_gen
    import ref_period_pkg::*;
#(
    parameter int unsigned PER_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lp_init,
    input  logic             tick_en,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_addr,
    input  logic [PER_W-1:0] bus_wdata,
    output logic [PER_W-1:0] bus_rdata,
    input  logic             pb_fixed,
    input  logic             vff_in,
    output logic             ref_out
);
    logic [PER_W-1:0] act_per, buf_per, cnt_q;
    logic             match, reload, force_xfer;
    ctrl_t            ctrl;

    rpg_regs #(.PER_W(PER_W)) u_regs (
        .clk(clk), .rst(rst), .lp_init(lp_init),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .match(match),
        .bus_rdata(bus_rdata), .act_per(act_per), .buf_per(buf_per),
        .ctrl(ctrl), .force_xfer(force_xfer)
    );

    rpg_vsync #(.SYNC_STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst(rst), .vff_in(vff_in),
        .rl_en(ctrl.rl_en), .edge_fall(ctrl.edge_fall), .gate(pb_fixed),
        .reload(reload)
    );

    rpg_counter #(.PER_W(PER_W)) u_cnt (
        .clk(clk), .rst(rst), .lp_init(lp_init), .tick_en(tick_en),
        .act_per(act_per), .reload(reload),
        .cnt_q(cnt_q), .match(match), .ref_out(ref_out)
    );
endmodule

// File: rtl/ref_period_chk.sv
module ref_period_chk #(
    parameter int unsigned PER_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             lp_init,
    input logic             tick_en,
    input logic             ref_out,
    input logic [PER_W-1:0] cnt,
    input logic [PER_W-1:0] act,
    input logic [PER_W-1:0] shd,
    input logic             reload,
    input logic             force_xfer
);
    localparam logic [PER_W-1:0] ONES = '1;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!ref_out && cnt == '0 && act == ONES && shd == ONES));

    a_r2_toggle_on_match: assert property (@(posedge clk) disable iff (rst || lp_init)
        (tick_en && cnt == act && !reload) |=> (ref_out != $past(ref_out) && cnt == '0));

    a_r3_active_holds: assert property (@(posedge clk) disable iff (rst || lp_init)
        (!(tick_en && cnt == act) && !force_xfer) |=> $stable(act));

    a_r4_forced_copy: assert property (@(posedge clk) disable iff (rst || lp_init)
        force_xfer |=> (act == $past(shd)));

    a_r5_low_power_init: assert property (@(posedge clk) disable iff (rst)
        lp_init |=> (act == ONES && shd == ONES && !ref_out && cnt == '0));

    a_r9_reload_clears: assert property (@(posedge clk) disable iff (rst || lp_init)
        reload |=> (cnt == '0 && ref_out == $past(ref_out)));

    a_r10_hold_count: assert property (@(posedge clk) disable iff (rst || lp_init)
        (!tick_en && !reload) |=> $stable(cnt));
endmodule

bind ref_period_gen ref_period_chk #(.PER_W(PER_W)) u_chk (
    .clk(clk), .rst(rst), .lp_init(lp_init), .tick_en(tick_en),
    .ref_out(ref_out), .cnt(cnt_q), .act(act_per), .shd(buf_per),
    .reload(reload), .force_xfer(force_xfer)
);

// File: tb/ref_period_gen_bench.sv
`timescale 1ns/100ps
module ref_period_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lp_init = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pb_fixed = 1'b0;
    logic        vff_in = 1'b0;
    logic        ref_out;

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    gap_mode = 1'b0;
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    ref_period_gen u_ref_period_gen (
        .clk(clk), .rst(rst), .lp_init(lp_init), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pb_fixed(pb_fixed), .vff_in(vff_in), .ref_out(ref_out)
    );

    task automatic check(input bit ok, input string req, input int act_v, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act_v, exp_v, $time);
        end
    endtask

    // Behavioural reference model
    logic [15:0] m_cnt, m_act, m_buf;
    bit m_out, m_en, m_fall, v1, v2, v3;
    always @(posedge clk) begin
        bit hit, mt, fx;
        if (rst) begin
            m_cnt = 0; m_out = 0; m_act = 16'hFFFF; m_buf = 16'hFFFF;
            m_en = 0; m_fall = 0; v1 = 0; v2 = 0; v3 = 0;
        end else begin
            hit = m_en && pb_fixed && (m_fall ? (v3 && !v2) : (v2 && !v3));
            v3 = v2; v2 = v1; v1 = vff_in;
            if (bus_sel && bus_wr && bus_addr) begin
                m_en = bus_wdata[0]; m_fall = bus_wdata[1];
            end
            if (lp_init) begin
                m_cnt = 0; m_out = 0; m_act = 16'hFFFF; m_buf = 16'hFFFF;
            end else begin
                mt = tick_en && (m_cnt == m_act) && !hit;
                fx = bus_sel && bus_rd && !bus_addr;
                if (mt || fx) m_act = m_buf;
                if (bus_sel && bus_wr && !bus_addr) m_buf = bus_wdata;
                if (hit) m_cnt = 0;
                else if (mt) begin m_cnt = 0; m_out = !m_out; end
                else if (tick_en) m_cnt = m_cnt + 16'd1;
            end
        end
    end

    // Compare on every cycle, mid-period
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [15:0] exp_rd;
            exp_rd = (bus_sel && bus_rd && bus_addr) ? {14'b0, m_fall, m_en} : 16'h0;
            check(ref_out == m_out, cur_req, ref_out, m_out);
            check(bus_rdata == exp_rd, cur_req, bus_rdata, exp_rd);
        end
    end

    always @(posedge clk) begin
        #1;
        if (gap_mode) tick_en = ~tick_en;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(input bit addr, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = addr; bus_wdata = d;
        step();
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input bit addr, output logic [15:0] d);
        bus_sel = 1; bus_rd = 1; bus_addr = addr;
        #0.5 d = bus_rdata;
        step();
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic wait_toggle();
        logic p;
        int guard = 0;
        p = ref_out;
        do begin step(); guard++; end while (ref_out == p && guard < 2000);
    endtask

    task automatic count_to_toggle(output int n);
        logic p;
        n = 0; p = ref_out;
        do begin step(); n++; end while (ref_out == p && n < 2000);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run ended)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        logic [15:0] rd;
        logic lvl;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        check(ref_out == 1'b0, "R1", ref_out, 0);
        bus_read(1'b1, rd);
        check(rd == 16'h0, "R1", rd, 0);

        // R2 basic half-period
        cur_req = "R2";
        tick_en = 1;
        bus_write(1'b0, 16'd5);
        bus_read(1'b0, rd);
        wait_toggle();
        count_to_toggle(n);
        check(n == 6, "R2", n, 6);

        // R10 enable every other cycle
        cur_req = "R10";
        gap_mode = 1;
        wait_toggle();
        count_to_toggle(n);
        check(n == 12, "R10", n, 12);
        gap_mode = 0;
        step();
        tick_en = 1;

        // R3 buffered write
        cur_req = "R3";
        wait_toggle();
        bus_write(1'b0, 16'd9);
        count_to_toggle(n);
        check(n == 5, "R3", n, 5);
        count_to_toggle(n);
        check(n == 10, "R3", n, 10);

        // R4 forced transfer by read
        cur_req = "R4";
        wait_toggle();
        bus_write(1'b0, 16'd3);
        lvl = ref_out;
        bus_read(1'b0, rd);
        check(rd == 16'h0, "R4", rd, 0);
        check(ref_out == lvl, "R4", ref_out, lvl);
        count_to_toggle(n);
        check(n == 2, "R4", n, 2);
        count_to_toggle(n);
        check(n == 4, "R4", n, 4);

        // Period 20 for the video tests
        cur_req = "R2";
        wait_toggle();
        bus_write(1'b0, 16'd20);
        bus_read(1'b0, rd);
        wait_toggle();
        count_to_toggle(n);
        check(n == 21, "R2", n, 21);

        // R6 control register
        cur_req = "R6";
        bus_write(1'b1, 16'hFFFD);
        bus_read(1'b1, rd);
        check(rd == 16'h0001, "R6", rd, 1);
        bus_write(1'b1, 16'h0002);
        bus_read(1'b1, rd);
        check(rd == 16'h0002, "R6", rd, 2);

        // R7 rising-edge reload
        cur_req = "R7";
        bus_write(1'b1, 16'h0001);
        pb_fixed = 1;
        wait_toggle();
        vff_in = 1;
        count_to_toggle(n);
        check(n == 24, "R7", n, 24);

        // R7 falling-edge reload
        bus_write(1'b1, 16'h0003);
        wait_toggle();
        vff_in = 0;
        count_to_toggle(n);
        check(n == 24, "R7", n, 24);

        // R8 unselected edge ignored
        cur_req = "R8";
        wait_toggle();
        vff_in = 1;
        count_to_toggle(n);
        check(n == 21, "R8", n, 21);

        // R8 pb_fixed low ignored
        bus_write(1'b1, 16'h0001);
        vff_in = 0;
        pb_fixed = 0;
        repeat (4) step();
        wait_toggle();
        vff_in = 1;
        count_to_toggle(n);
        check(n == 21, "R8", n, 21);

        // R8 reload disabled ignored
        bus_write(1'b1, 16'h0000);
        pb_fixed = 1;
        vff_in = 0;
        repeat (4) step();
        wait_toggle();
        vff_in = 1;
        count_to_toggle(n);
        check(n == 21, "R8", n, 21);

        // R9 reload coincides with match
        cur_req = "R9";
        bus_write(1'b1, 16'h0001);
        vff_in = 0;
        repeat (4) step();
        wait_toggle();
        repeat (18) step();
        vff_in = 1;
        count_to_toggle(n);
        check(n == 24, "R9", n, 24);

        // R5 low-power initialisation
        cur_req = "R5";
        pb_fixed = 0;
        lp_init = 1;
        bus_write(1'b0, 16'd2);
        step();
        check(ref_out == 1'b0, "R5", ref_out, 0);
        bus_read(1'b1, rd);
        check(rd == 16'h0001, "R5", rd, 1);
        lp_init = 0;
        n = 0;
        repeat (100) begin
            step();
            if (ref_out) n++;
        end
        check(n == 0, "R5", n, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule